// File: doc/BRIEF.md
# Length-Limited Replayable Transmit Buffer

This block holds one outgoing packet of up to 16 bytes for a transmitter. Firmware fills it through a single register address with a write strobe. The address does not advance, so each strobe appends the next byte. A programmed packet length sets how many bytes the buffer accepts. Writes past that limit are dropped without any effect.

A start command streams the stored bytes to the transmitter in the order they were written. The stream uses a valid/ready handshake. Sending does not consume the contents, so a later start without a clear sends the same packet again. A clear command empties the buffer.

An automatic acknowledge frame can also be started. It comes from a fixed parameter word, is sent least significant byte first on the same stream, and never touches the buffer.

Top module: `txpkt_buffer`

## Requirements
- R1: After reset the stream is idle: `tx_valid` and `tx_busy` are low, and the buffer holds no bytes.
- R2: Each cycle with `wr_en` high, and no clear, stores `wr_data` in the next free slot. A started packet sends the stored bytes in write order, one byte per handshake.
- R3: The buffer accepts at most min(`pkt_len`, 16) bytes. Further writes are discarded and leave the sent packet unchanged.
- R4: Sending a packet does not empty the buffer. A later `tx_go` without a clear sends the identical bytes again.
- R5: `clr` empties the buffer, and the next write goes to slot 0.
- R6: `ack_go` sends a 2-byte acknowledge frame built from parameter `ACK_WORD`. Bits 7:0 go out first, then bits 15:8. The buffer contents and fill state are not changed.
- R7: `tx_go` or `ack_go` arriving while `tx_busy` is high is ignored. `tx_busy` rises in the cycle after an accepted start and falls after the handshake of the byte flagged `tx_last`.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. A byte transfers on a cycle with both high, and `tx_last` marks the final byte of each frame.
- R9: A `tx_go` with no stored bytes is ignored and `tx_busy` stays low. A `pkt_len` of 0 means no byte is accepted.
- R10: When `clr` and `wr_en` are high in the same cycle, the clear wins and the write is dropped.
- R11: When idle `tx_go` (with bytes stored) and `ack_go` arrive in the same cycle, the data packet is sent and the acknowledge request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe to the buffer address |
| wr_data | input | 8 | Byte to append |
| pkt_len | input | 8 | Programmed packet length |
| clr | input | 1 | Empties the buffer |
| tx_go | input | 1 | Starts sending the stored packet |
| ack_go | input | 1 | Starts sending the acknowledge frame |
| tx_ready | input | 1 | Transmitter accepts a byte |
| tx_valid | output | 1 | Byte on `tx_data` is offered |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Offered byte is the last of its frame |
| tx_busy | output | 1 | A frame is in progress |

## Verification
Several of the block's functions can fall in the same cycle, and the bench provokes each such collision deliberately:

- **Clear against write.** A clear and a write strobe are raised together. The bench then writes fresh bytes and expects only those in the next packet.
- **Data start against acknowledge start.** `tx_go` and `ack_go` are pulsed in the same idle cycle. The scoreboard must see the data packet and no acknowledge bytes.
- **Start while busy.** A second start is pulsed in the middle of a long packet under back-pressure. The bench then checks that `tx_busy` does not rise again.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_ACK  = 2'd2
  } drain_state_e;
endpackage

// File: rtl/txbuf_fill.sv
module txbuf_fill #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             slot_we,
  output logic [PTR_W-1:0] slot_idx,
  output logic [CNT_W-1:0] stored
);
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] fill_q;

  always_comb begin
    if (pkt_len > LEN_W'(DEPTH)) cap = CNT_W'(DEPTH);
    else                         cap = CNT_W'(pkt_len);
  end

  assign slot_we  = wr_en && !clr && (fill_q < cap);
  assign slot_idx = fill_q[PTR_W-1:0];
  assign stored   = fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       fill_q <= '0;
    else if (clr)     fill_q <= '0;
    else if (slot_we) fill_q <= fill_q + 1'b1;
  end

  // R3
  drop_past_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && fill_q >= cap) |=> $stable(fill_q));
  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0));
  // R10
  clear_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_en) |-> !slot_we);
  // R3
  fill_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && waddr == PTR_W'(g)) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/txbuf_drain.sv
module txbuf_drain
  import txbuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int W         = 8,
  parameter int ACK_BYTES = 2,
  parameter logic [ACK_BYTES*W-1:0] ACK_WORD = 16'hA55A,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_go,
  input  logic             ack_go,
  input  logic [CNT_W-1:0] stored,
  input  logic             tx_ready,
  input  logic [W-1:0]     buf_byte,
  output logic [PTR_W-1:0] rd_addr,
  output logic             tx_valid,
  output logic [W-1:0]     tx_data,
  output logic             tx_last,
  output logic             tx_busy
);
  drain_state_e     state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] last_q;
  logic [ACK_BYTES*W-1:0] ack_shift;
  logic             xfer;

  assign xfer      = tx_valid && tx_ready;
  assign tx_valid  = (state_q != ST_IDLE);
  assign tx_busy   = tx_valid;
  assign tx_last   = tx_valid && (idx_q == last_q);
  assign rd_addr   = idx_q[PTR_W-1:0];
  assign ack_shift = ACK_WORD >> (W * int'(idx_q));
  assign tx_data   = (state_q == ST_ACK) ? ack_shift[W-1:0] : buf_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tx_go && stored != '0) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            last_q  <= stored - 1'b1;
          end else if (ack_go) begin
            state_q <= ST_ACK;
            idx_q   <= '0;
            last_q  <= CNT_W'(ACK_BYTES - 1);
          end
        end
        default: begin
          if (xfer) begin
            if (idx_q == last_q) state_q <= ST_IDLE;
            else                 idx_q   <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !xfer) |=> $stable(idx_q));
  // R7
  busy_ends_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && tx_last) |=> !tx_busy);
  // R9
  empty_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && stored == '0 && !ack_go) |=> !tx_busy);
endmodule

// File: rtl/txpkt_buffer.sv
module txpkt_buffer
  import txbuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int W         = 8,
  parameter int LEN_W     = 8,
  parameter int ACK_BYTES = 2,
  parameter logic [ACK_BYTES*W-1:0] ACK_WORD = 16'hA55A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             clr,
  input  logic             tx_go,
  input  logic             ack_go,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [W-1:0]     tx_data,
  output logic             tx_last,
  output logic             tx_busy
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             slot_we;
  logic [PTR_W-1:0] slot_idx;
  logic [CNT_W-1:0] stored;
  logic [PTR_W-1:0] rd_addr;
  logic [W-1:0]     buf_byte;

  txbuf_fill #(.DEPTH(DEPTH), .LEN_W(LEN_W)) fill_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr), .pkt_len(pkt_len),
    .slot_we(slot_we), .slot_idx(slot_idx), .stored(stored)
  );

  txbuf_store #(.DEPTH(DEPTH), .W(W)) store_i (
    .clk(clk), .we(slot_we), .waddr(slot_idx), .wdata(wr_data),
    .raddr(rd_addr), .rdata(buf_byte)
  );

  txbuf_drain #(.DEPTH(DEPTH), .W(W), .ACK_BYTES(ACK_BYTES), .ACK_WORD(ACK_WORD)) drain_i (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .ack_go(ack_go), .stored(stored),
    .tx_ready(tx_ready), .buf_byte(buf_byte), .rd_addr(rd_addr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_busy(tx_busy)
  );

  // R6
  ack_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !slot_we && !clr) |=> $stable(stored));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!tx_valid && stored == '0));
endmodule

// File: tb/txpkt_buffer_tb_top.sv
module txpkt_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] pkt_len = '0;
  logic       clr = 1'b0;
  logic       tx_go = 1'b0;
  logic       ack_go = 1'b0;
  logic       tx_ready = 1'b1;
  logic       tx_valid, tx_last, tx_busy;
  logic [7:0] tx_data;

  localparam logic [15:0] ACK = 16'hC33D;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_mode = 0;
  logic [8:0] sb_q[$];
  logic [7:0] model_mem [16];
  int model_cnt = 0;

  always #10 clk = ~clk;

  txpkt_buffer #(.ACK_WORD(ACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pkt_len(pkt_len),
    .clr(clr), .tx_go(tx_go), .ack_go(ack_go), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_busy(tx_busy)
  );

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
    #1;
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= (cyc % 4) != 3;
      default: tx_ready <= (cyc % 6) > 3;
    endcase
  end

  // scoreboard monitor (R2, R8)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected byte", int'(tx_data), 0);
      end else begin
        logic [8:0] e;
        e = sb_q.pop_front();
        check({tx_last, tx_data} == e, "R2/R8 byte+last", int'({tx_last, tx_data}), int'(e));
      end
    end
  end

  task automatic write_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b1;
      wr_data = 8'(seed + 7 * i);
      if (model_cnt < ((pkt_len > 16) ? 16 : int'(pkt_len))) begin
        model_mem[model_cnt] = wr_data;
        model_cnt++;
      end
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_clear();
    @(posedge clk); #1;
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    model_cnt = 0;
  endtask

  task automatic push_packet();
    for (int i = 0; i < model_cnt; i++)
      sb_q.push_back({(i == model_cnt - 1), model_mem[i]});
  endtask

  task automatic push_ack();
    sb_q.push_back({1'b0, ACK[7:0]});
    sb_q.push_back({1'b1, ACK[15:8]});
  endtask

  task automatic pulse(input bit go, input bit ack);
    @(posedge clk); #1;
    tx_go = go;
    ack_go = ack;
    @(posedge clk); #1;
    tx_go = 1'b0;
    ack_go = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!tx_busy, req, int'(tx_busy), 0);
    check(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!tx_valid && !tx_busy, "R1 reset idle", int'({tx_valid, tx_busy}), 0);
    pulse(1'b1, 1'b0);
    @(negedge clk);
    // R1 R9 empty go
    check(!tx_busy, "R1/R9 go on empty", int'(tx_busy), 0);

    // R2 basic packet
    pkt_len = 8'd5;
    write_bytes(5, 8'h11);
    push_packet();
    pulse(1'b1, 1'b0);
    wait_idle("R2 packet done");

    // R3 extra writes dropped, R4 replay
    write_bytes(3, 8'hE0);
    push_packet();
    pulse(1'b1, 1'b0);
    wait_idle("R3/R4 replay after overflow");

    // R6 ack LSB first, then buffer still intact
    rdy_mode = 1;
    push_ack();
    pulse(1'b0, 1'b1);
    wait_idle("R6 ack frame");
    push_packet();
    pulse(1'b1, 1'b0);
    wait_idle("R6/R4 replay after ack");

    // R5 clear then R3 clamp at 16
    do_clear();
    pkt_len = 8'd20;
    write_bytes(18, 8'h40);
    check(model_cnt == 16, "R3 clamp model", model_cnt, 16);
    rdy_mode = 2;
    push_packet();
    pulse(1'b1, 1'b0);
    // R7 start and ack while busy ignored
    repeat (6) @(posedge clk);
    pulse(1'b1, 1'b1);
    wait_idle("R7 restart ignored");
    rdy_mode = 1;

    // R9 zero length accepts nothing
    do_clear();
    pkt_len = 8'd0;
    write_bytes(3, 8'h77);
    pulse(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check(!tx_busy, "R9 zero length", int'(tx_busy), 0);

    // R10 clear and write in same cycle
    pkt_len = 8'd4;
    @(posedge clk); #1;
    clr = 1'b1; wr_en = 1'b1; wr_data = 8'hBB;
    @(posedge clk); #1;
    clr = 1'b0; wr_en = 1'b0;
    model_cnt = 0;
    write_bytes(2, 8'h90);
    push_packet();
    pulse(1'b1, 1'b0);
    wait_idle("R10 clear beats write");

    // R11 go and ack same idle cycle
    rdy_mode = 0;
    push_packet();
    pulse(1'b1, 1'b1);
    wait_idle("R11 data wins over ack");

    // R5 writes after clear start at slot 0
    do_clear();
    pkt_len = 8'd3;
    write_bytes(3, 8'h05);
    push_packet();
    pulse(1'b1, 1'b0);
    wait_idle("R5 refill after clear");

    finish_run();
  end
endmodule